// File: doc/BRIEF.md
# Dual-Channel Serial Step-Attenuator Programmer

This block sits on the host side of two 6-bit digital step attenuators and writes a new attenuation code into either of them over a three-wire serial link. Each link has a serial clock, a data line and a latch strobe. A request names a channel and supplies either a raw code or an attenuation in half-dB units. One code step is 0.5 dB, so the full range is 31.5 dB. Code 0 gives the highest gain and code 63 gives the lowest.

After it accepts a request, the block shifts the code out one bit per serial clock period, most significant bit first. The receiver samples data on the rising serial clock edge, so the block changes data only while the clock is low. Once the sixth bit has been clocked, the block drives the channel's latch strobe for one serial clock period, and the new state takes effect at that point. The serial clock runs at a fixed ratio of the system clock and has equal high and low times. With a 200 MHz system clock and the default ratio, the serial clock is about 33 MHz, below the 40 MHz limit. Data is then stable 15 ns before and 15 ns after every rising edge, which meets the 3 ns setup and 7 ns hold margins.

A build parameter selects between two pin arrangements. In the dedicated arrangement, each channel has its own clock and data lines. In the shared arrangement, both channels see the same clock and data waveform. In both arrangements, each channel keeps its own latch strobe, and only the addressed channel's strobe pulses.

Top module: `atten_prog`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` is then high for exactly 14*HALF_DIV cycles, starting in the cycle after acceptance.
- R2: The six code bits appear on the addressed data line most significant bit first. Six rising serial clock edges occur per request, and the word sampled at those edges equals the requested code.
- R3: A data line never changes while its serial clock is high, and it never changes in the cycle in which its serial clock rises.
- R4: The serial clock idles low. Each high time and each low time between bits lasts exactly HALF_DIV system clock cycles.
- R5: The latch strobe rises in the same cycle as the sixth falling edge of the serial clock. It stays high for 2*HALF_DIV cycles, and the serial clock stays low throughout.
- R6: `done` is high for exactly one cycle: the first cycle after the latch strobe falls. In that cycle `busy` is already low, so a waiting request is accepted on the following edge.
- R7: `req_chan` = 0 addresses lane 0 and `req_chan` = 1 addresses lane 1 (bit 0 of each lane bus). At most one latch strobe is high at a time, and only the addressed lane's strobe pulses. With SHARED = 0, the other lane's clock and data stay low.
- R8: With SHARED = 1, both lanes carry identical clock and data waveforms, equal to the addressed lane's waveform in the dedicated arrangement. The latch strobes are unchanged.
- R9: When `req_use_halfdb` = 1, the code sent is `req_halfdb` if that value is 63 or less, and 63 (all ones) otherwise. `req_code` is then ignored. When `req_use_halfdb` = 0, the code sent is `req_code`.
- R10: During reset, `busy`, `done`, every serial clock, every data line and every latch strobe are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_chan | input | 1 | Channel to program |
| req_use_halfdb | input | 1 | 1: use `req_halfdb`; 0: use `req_code` |
| req_code | input | 6 | Raw attenuation code |
| req_halfdb | input | 8 | Attenuation in half-dB units, saturated to 63 |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| ser_clk | output | 2 | Serial clock, one per lane |
| ser_data | output | 2 | Serial data, one per lane |
| ser_le | output | 2 | Latch strobe, one per lane |

## Verification
Several rules are checked by the in-RTL assertions on every cycle:

- Data stays stable while the serial clock is high.
- The strobe begins on a falling clock edge.
- `done` is a single-cycle pulse that follows the strobe.
- At most one strobe is high, and all lines are quiet when idle.
- The half-period counter stays in range.

The bench scenarios are the only check of the rest: that the sampled word equals the requested code for each channel and for the half-dB saturation cases, the exact clock, strobe and busy durations, back-to-back acceptance, silence on the unaddressed dedicated lane, and equality of the shared-line variant with the dedicated one.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_LATCH = 2'd2
  } seq_state_t;
endpackage

// File: rtl/atten_rst_sync.sv
module atten_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/atten_code_sel.sv
module atten_code_sel #(
  parameter int CODE_W = 6,
  parameter int HDB_W  = 8
) (
  input  logic              use_hdb,
  input  logic [CODE_W-1:0] code_in,
  input  logic [HDB_W-1:0]  hdb_in,
  output logic [CODE_W-1:0] code_out
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  always_comb begin
    if (!use_hdb)                          code_out = code_in;
    else if (hdb_in > HDB_W'(MAX_CODE))    code_out = '1;
    else                                   code_out = hdb_in[CODE_W-1:0];
  end
endmodule

// File: rtl/atten_half_timer.sv
module atten_half_timer #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HALF_DIV));
endmodule

// File: rtl/atten_serializer.sv
module atten_serializer
  import atten_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int CH_W     = 1,
  parameter int HALF_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CH_W-1:0]   chan_in,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              sdata,
  output logic              latch,
  output logic [CH_W-1:0]   chan
);
  localparam int BW = (CODE_W < 2) ? 1 : $clog2(CODE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(CODE_W - 1);

  seq_state_t        state_q, state_d;
  logic              ph_q, ph_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CODE_W-1:0] sreg_q, sreg_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              done_q, done_d;
  logic              tick;

  atten_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q != SEQ_IDLE),
    .tick (tick)
  );

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sreg_d  = sreg_q;
    chan_d  = chan_q;
    done_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_SHIFT;
          ph_d    = 1'b0;
          bit_d   = '0;
          sreg_d  = code_in;
          chan_d  = chan_in;
        end
      end
      SEQ_SHIFT: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d   = 1'b0;
            sreg_d = sreg_q << 1;
            if (bit_q == LAST_BIT) state_d = SEQ_LATCH;
            else                   bit_d   = bit_q + 1'b1;
          end
        end
      end
      SEQ_LATCH: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d    = 1'b0;
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ph_q    <= 1'b0;
      bit_q   <= '0;
      sreg_q  <= '0;
      chan_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sreg_q  <= sreg_d;
      chan_q  <= chan_d;
      done_q  <= done_d;
    end
  end

  assign busy  = (state_q != SEQ_IDLE);
  assign sclk  = (state_q == SEQ_SHIFT) && ph_q;
  assign latch = (state_q == SEQ_LATCH);
  assign sdata = sreg_q[CODE_W-1];
  assign chan  = chan_q;
  assign done  = done_q;

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));
  assert_strobe_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> $past(sclk));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(latch)));
  assert_busy_from_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/atten_lane_route.sv
module atten_lane_route #(
  parameter int N_CH   = 2,
  parameter int CH_W   = 1,
  parameter bit SHARED = 1'b0
) (
  input  logic            sclk,
  input  logic            sdata,
  input  logic            latch,
  input  logic [CH_W-1:0] chan,
  output logic [N_CH-1:0] lane_clk,
  output logic [N_CH-1:0] lane_data,
  output logic [N_CH-1:0] lane_le
);
  for (genvar l = 0; l < N_CH; l++) begin : g_lane
    logic sel;
    assign sel        = (chan == CH_W'(l));
    assign lane_le[l] = latch && sel;
    if (SHARED) begin : g_shared
      assign lane_clk[l]  = sclk;
      assign lane_data[l] = sdata;
    end else begin : g_dedicated
      assign lane_clk[l]  = sclk && sel;
      assign lane_data[l] = sdata && sel;
    end
  end
endmodule

// File: rtl/atten_prog.sv
module atten_prog #(
  parameter int CODE_W   = 6,
  parameter int HDB_W    = 8,
  parameter int N_CH     = 2,
  parameter int HALF_DIV = 3,
  parameter bit SHARED   = 1'b0,
  localparam int CH_W    = (N_CH < 2) ? 1 : $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_use_halfdb,
  input  logic [CODE_W-1:0] req_code,
  input  logic [HDB_W-1:0]  req_halfdb,
  output logic              busy,
  output logic              done,
  output logic [N_CH-1:0]   ser_clk,
  output logic [N_CH-1:0]   ser_data,
  output logic [N_CH-1:0]   ser_le
);
  logic              rst_n_i;
  logic [CODE_W-1:0] code_sel;
  logic              start;
  logic              sclk, sdata, latch;
  logic [CH_W-1:0]   chan;

  atten_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  atten_code_sel #(.CODE_W(CODE_W), .HDB_W(HDB_W)) u_sel (
    .use_hdb (req_use_halfdb),
    .code_in (req_code),
    .hdb_in  (req_halfdb),
    .code_out(code_sel)
  );

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  atten_serializer #(.CODE_W(CODE_W), .CH_W(CH_W), .HALF_DIV(HALF_DIV)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (start),
    .code_in(code_sel),
    .chan_in(req_chan),
    .busy   (busy),
    .done   (done),
    .sclk   (sclk),
    .sdata  (sdata),
    .latch  (latch),
    .chan   (chan)
  );

  atten_lane_route #(.N_CH(N_CH), .CH_W(CH_W), .SHARED(SHARED)) u_route (
    .sclk     (sclk),
    .sdata    (sdata),
    .latch    (latch),
    .chan     (chan),
    .lane_clk (ser_clk),
    .lane_data(ser_data),
    .lane_le  (ser_le)
  );

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(ser_le));
  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !busy |-> (ser_clk == '0 && ser_le == '0));
endmodule

// File: tb/tb_atten_prog.sv
module tb_atten_prog;
  localparam int HALF = 3;

  logic clk, rst_n;
  logic req_valid, req_chan, req_use_halfdb;
  logic [5:0] req_code;
  logic [7:0] req_halfdb;
  logic req_ready, busy, done;
  logic [1:0] ser_clk, ser_data, ser_le;
  logic sh_ready, sh_busy, sh_done;
  logic [1:0] sh_clk, sh_data, sh_le;

  atten_prog #(.HALF_DIV(HALF), .SHARED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_use_halfdb(req_use_halfdb), .req_code(req_code),
    .req_halfdb(req_halfdb), .busy(busy), .done(done),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

  atten_prog #(.HALF_DIV(HALF), .SHARED(1'b1)) dut_sh (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(sh_ready),
    .req_chan(req_chan), .req_use_halfdb(req_use_halfdb), .req_code(req_code),
    .req_halfdb(req_halfdb), .busy(sh_busy), .done(sh_done),
    .ser_clk(sh_clk), .ser_data(sh_data), .ser_le(sh_le));

  typedef struct packed { logic chan; logic [5:0] code; } item_t;
  item_t exp_q[$];

  int tests = 0, fails = 0, cycles = 0;
  bit running = 1'b0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic ch, input logic [5:0] code, input logic use_h, input logic [7:0] hdb);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_code = code;
    req_use_halfdb = use_h; req_halfdb = hdb;
    it.chan = ch;
    it.code = use_h ? ((hdb > 8'd63) ? 6'd63 : hdb[5:0]) : code;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  logic [1:0] pc, pd, ple;
  int lo_run[2], hi_run[2], nb[2];
  logic [5:0] acc[2];
  int r3_bad, r4_bad, r7_bad, r8_bad, le_run, busy_run;
  bit after_done;

  always @(negedge clk) begin
    if (running) begin
      if (busy) busy_run++;
      if (after_done) begin
        if (exp_q.size() > 0) chk(busy == 1'b1, "R1 back-to-back accept", busy, 1);
        after_done = 1'b0;
      end
      if (sh_clk[0] != sh_clk[1] || sh_clk[0] != |ser_clk ||
          sh_data[0] != sh_data[1] || sh_data[0] != |ser_data || sh_le != ser_le)
        r8_bad++;
      if (done && !(ple != 2'b00 && ser_le == 2'b00))
        chk(1'b0, "R6 stray done", 1, 0);
      for (int c = 0; c < 2; c++) begin
        if (ser_clk[c] && (exp_q.size() == 0 || exp_q[0].chan != c[0])) r7_bad++;
        if (ser_data[c] && (exp_q.size() == 0 || exp_q[0].chan != c[0])) r7_bad++;
        if (ser_clk[c] && !pc[c]) begin
          if (ser_data[c] != pd[c]) r3_bad++;
          if (nb[c] > 0 && lo_run[c] != HALF) r4_bad++;
          acc[c] = {acc[c][4:0], ser_data[c]};
          nb[c]++;
          hi_run[c] = 1;
        end else if (ser_clk[c] && pc[c]) begin
          hi_run[c]++;
          if (ser_data[c] != pd[c]) r3_bad++;
        end else if (!ser_clk[c] && pc[c]) begin
          if (hi_run[c] != HALF) r4_bad++;
          lo_run[c] = 1;
        end else begin
          lo_run[c]++;
        end
        if (ser_le[c] && !ple[c]) begin
          chk(!ser_clk[c] && pc[c], "R5 strobe on sixth fall", ser_clk[c], 0);
          chk(exp_q.size() > 0 && exp_q[0].chan == c[0], "R7 strobe lane", c, exp_q.size() > 0 ? int'(exp_q[0].chan) : -1);
          chk(nb[c] == 6, "R2 rising edge count", nb[c], 6);
          chk(exp_q.size() > 0 && acc[c] == exp_q[0].code, "R2/R9 sampled word", acc[c], exp_q.size() > 0 ? int'(exp_q[0].code) : -1);
          le_run = 1;
        end else if (ser_le[c] && ple[c]) begin
          le_run++;
          if (ser_clk[c]) r4_bad++;
        end else if (!ser_le[c] && ple[c]) begin
          chk(le_run == 2 * HALF, "R5 strobe width", le_run, 2 * HALF);
          chk(done && !busy, "R6 done after strobe", {done, busy}, 2);
          chk(busy_run == 14 * HALF, "R1 busy length", busy_run, 14 * HALF);
          chk(r3_bad == 0, "R3 data stable around rise", r3_bad, 0);
          chk(r4_bad == 0, "R4 clock timing", r4_bad, 0);
          chk(r7_bad == 0, "R7 other lane quiet", r7_bad, 0);
          chk(r8_bad == 0, "R8 shared lines match", r8_bad, 0);
          void'(exp_q.pop_front());
          nb[c] = 0; busy_run = 0; after_done = 1'b1;
          r3_bad = 0; r4_bad = 0; r7_bad = 0; r8_bad = 0;
        end
      end
    end
    pc = ser_clk; pd = ser_data; ple = ser_le;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0; req_chan = 1'b0; req_use_halfdb = 1'b0;
    req_code = '0; req_halfdb = '0;
    pc = '0; pd = '0; ple = '0;
    for (int c = 0; c < 2; c++) begin lo_run[c] = 0; hi_run[c] = 0; nb[c] = 0; acc[c] = '0; end
    r3_bad = 0; r4_bad = 0; r7_bad = 0; r8_bad = 0; le_run = 0; busy_run = 0; after_done = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && req_ready, "R10 reset handshake", {busy, done, req_ready}, 1);
    chk(ser_clk == 0 && ser_data == 0 && ser_le == 0, "R10 reset lines", {ser_clk, ser_data, ser_le}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    // R2/R7: raw codes on both lanes, edge patterns
    send(1'b0, 6'h00, 1'b0, 8'd0);
    send(1'b1, 6'h3F, 1'b0, 8'd0);
    send(1'b0, 6'h2A, 1'b0, 8'd0);
    send(1'b1, 6'h15, 1'b0, 8'd0);
    repeat (7) @(negedge clk);
    send(1'b0, 6'h21, 1'b0, 8'd0);
    // R9: half-dB input, code input ignored, saturation
    send(1'b1, 6'h15, 1'b1, 8'd37);
    send(1'b0, 6'h00, 1'b1, 8'd63);
    send(1'b1, 6'h00, 1'b1, 8'd64);
    send(1'b0, 6'h2A, 1'b1, 8'd200);
    send(1'b1, 6'h3F, 1'b1, 8'd0);
    send(1'b0, 6'h3F, 1'b1, 8'd255);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!busy && ser_le == 0 && ser_clk == 0, "R4 idle after run", {busy, ser_le, ser_clk}, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule